// File: doc/BRIEF.md
# Printer Port Control Register

This block holds the host-writable control byte of a PC-style printer port. The printer-side handshake lines come from that byte. Each line has its own polarity: strobe, line-feed and select are driven inverted, and initialise is driven straight. The block also turns a rising edge on the acknowledge input into an interrupt request, and it sets the direction of the printer data bus according to the port mode.

The host writes the byte with a one-cycle write strobe and reads it back combinationally on `rdata`. A read cycle also acknowledges a pending interrupt. The acknowledge input is asynchronous. It passes through a two-flop synchroniser and then an edge detector, which feed a two-state interrupt machine. The two states are `IRQ_IDLE` and `IRQ_PEND`. The machine takes these transitions:
- *arm*: `IRQ_IDLE` to `IRQ_PEND`, on a synchronised rising edge while the enable bit is 1.
- *ack*: `IRQ_PEND` to `IRQ_IDLE`, on a read cycle that has no new edge in the same cycle.
- *mask*: `IRQ_PEND` to `IRQ_IDLE`, whenever the enable bit is 0.

The port mode comes from outside as a single input.

Top module: `prn_ctl_top`

## Requirements
- R1: `strobe_n` equals the inverse of register bit 0.
- R2: `autofd_n` equals the inverse of register bit 1. A 1 in bit 1 requests a line feed after each printed line.
- R3: `init_n` equals register bit 2, with no inversion.
- R4: `selin_n` equals the inverse of register bit 3. A 1 in bit 3 selects the printer.
- R5: `rdata` returns `{2'b00, bits[5:0]}` of the register at all times. Writes to bits 7 and 6 are discarded.
- R6: While `rst_n` is low and after it is released, the register is 0, `strobe_n`, `autofd_n` and `selin_n` are 1, and `init_n`, `irq` and `dir_in` are 0.
- R7: With bit 4 (interrupt enable) at 1, a low-to-high change on `ack_n` sets `irq` after the third rising clock edge following the change, and not earlier. A high-to-low change never sets it.
- R8: With bit 4 at 0, `irq` is 0 and acknowledge edges are not remembered. Setting bit 4 later does not raise `irq` for an earlier edge.
- R9: Once set, `irq` stays 1 until the clock edge ending a read cycle (`rd_en`=1), or until the write edge that clears bit 4; it reads 0 after either.
- R10: `dir_in` equals register bit 5 (1 = input, 0 = output) when `ext_mode` is 1, and is 0 when `ext_mode` is 0, whatever bit 5 holds.
- R11: Each acknowledge rising edge produces one request. Holding `ack_n` high after a read does not raise `irq` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| rd_en | input | 1 | Register read cycle; acknowledges a pending interrupt |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| ext_mode | input | 1 | 1 = extended (bidirectional) mode, 0 = plain printer mode |
| ack_n | input | 1 | Asynchronous acknowledge from the printer |
| strobe_n | output | 1 | Data strobe to the printer |
| autofd_n | output | 1 | Auto line-feed to the printer |
| init_n | output | 1 | Initialise to the printer |
| selin_n | output | 1 | Printer select |
| irq | output | 1 | Interrupt request level |
| dir_in | output | 1 | Data bus direction, 1 = input |

## Verification
The assertions check on every cycle the relations that hold at any time:
- After a write, each handshake line has its polarity and the read-back has bits 7:6 clear (R1, R3, R5).
- `irq` is never high with the enable bit clear (R8).
- The direction is forced to output outside extended mode (R10).
- A read cycle without a fresh edge drops the request (R9).
- A request only starts one cycle after a synchronised edge (R7, R11).

Only the bench scenarios can show the following:
- The exact three-edge latency from the pin (R7).
- That a disabled edge leaves no trace once the enable bit is set again (R8).
- That a held-high acknowledge yields exactly one request (R11).
- The reset values (R6).

// File: rtl/prn_ctl_pkg.sv
package prn_ctl_pkg;
    localparam int unsigned CTL_W   = 8;
    localparam int unsigned BIT_STB = 0;
    localparam int unsigned BIT_AFD = 1;
    localparam int unsigned BIT_INI = 2;
    localparam int unsigned BIT_SEL = 3;
    localparam int unsigned BIT_IEN = 4;
    localparam int unsigned BIT_DIR = 5;
    localparam int unsigned USED_W  = BIT_DIR + 1;
    localparam logic [CTL_W-1:0] CTL_MASK = CTL_W'((1 << USED_W) - 1);

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;
endpackage

// File: rtl/prn_ctl_sync.sv
module prn_ctl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], async_in};
        end
    end

    // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its previous value
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/prn_ctl_irq.sv
module prn_ctl_irq
    import prn_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic edge_seen,
    input  logic host_read,
    output logic irq
);
    irq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (enable && edge_seen) state_d = IRQ_PEND;      // arm
            end
            IRQ_PEND: begin
                if (!enable)                       state_d = IRQ_IDLE; // mask
                else if (host_read && !edge_seen)  state_d = IRQ_IDLE; // ack
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = (state_q == IRQ_PEND) && enable;
    end
endmodule

// File: rtl/prn_ctl_reg.sv
module prn_ctl_reg
    import prn_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] ctl_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= '0;
        else if (wr_en) ctl_q <= wdata & CTL_MASK;
    end
endmodule

// File: rtl/prn_ctl_top.sv
module prn_ctl_top
    import prn_ctl_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] rdata,
    input  logic             ext_mode,
    input  logic             ack_n,
    output logic             strobe_n,
    output logic             autofd_n,
    output logic             init_n,
    output logic             selin_n,
    output logic             irq,
    output logic             dir_in
);
    logic [CTL_W-1:0] ctl_q;
    logic             ack_rise;

    prn_ctl_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wdata (wdata),
        .ctl_q (ctl_q)
    );

    prn_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ack_n),
        .rise     (ack_rise)
    );

    prn_ctl_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (ctl_q[BIT_IEN]),
        .edge_seen (ack_rise),
        .host_read (rd_en),
        .irq       (irq)
    );

    always_comb begin
        strobe_n = ~ctl_q[BIT_STB];
        autofd_n = ~ctl_q[BIT_AFD];
        init_n   =  ctl_q[BIT_INI];
        selin_n  = ~ctl_q[BIT_SEL];
        dir_in   = ext_mode & ctl_q[BIT_DIR];
        rdata    = ctl_q;
    end
endmodule

// File: rtl/prn_ctl_chk.sv
module prn_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       ext_mode,
    input logic       strobe_n,
    input logic       init_n,
    input logic       irq,
    input logic       dir_in,
    input logic       ack_rise
);
    assert_strobe_pol_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (strobe_n == !$past(wdata[0])));

    assert_init_pol_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (init_n == $past(wdata[2])));

    assert_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rdata == {2'b00, $past(wdata[5:0])}));

    assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata[4] |-> !irq);

    assert_dir_printer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> !dir_in);

    assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ack_rise) |=> !irq);

    assert_irq_from_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) && !$past(wr_en) |-> $past(ack_rise));
endmodule

bind prn_ctl_top prn_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .rdata    (rdata),
    .ext_mode (ext_mode),
    .strobe_n (strobe_n),
    .init_n   (init_n),
    .irq      (irq),
    .dir_in   (dir_in),
    .ack_rise (ack_rise)
);

// File: tb/prn_ctl_top_tb.sv
module prn_ctl_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ext_mode = 1'b0;
    logic       ack_n = 1'b1;
    logic       strobe_n, autofd_n, init_n, selin_n, irq, dir_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prn_ctl_top u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ext_mode(ext_mode), .ack_n(ack_n),
        .strobe_n(strobe_n), .autofd_n(autofd_n), .init_n(init_n),
        .selin_n(selin_n), .irq(irq), .dir_in(dir_in)
    );

    // vector: wdata[21:14], ext[13], exp {strobe,autofd,init,selin,dir}[12:8], exp rdata[7:0]
    localparam int NV = 7;
    localparam logic [21:0] VEC [NV] = '{
        {8'h00, 1'b0, 5'b11010, 8'h00},
        {8'h01, 1'b0, 5'b01010, 8'h01},
        {8'h0E, 1'b0, 5'b10100, 8'h0E},
        {8'hFF, 1'b1, 5'b00101, 8'h3F},
        {8'hE0, 1'b0, 5'b11010, 8'h20},
        {8'hE0, 1'b1, 5'b11011, 8'h20},
        {8'h15, 1'b1, 5'b01110, 8'h15}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R6: reset values while held and after release
        chk("R6 outputs in reset", {26'd0, strobe_n, autofd_n, init_n, selin_n, irq, dir_in}, 32'b110100);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R6 outputs after reset", {26'd0, strobe_n, autofd_n, init_n, selin_n, irq, dir_in}, 32'b110100);
        chk("R6 register after reset", {24'd0, rdata}, 32'h00);

        // R1 R2 R3 R4 R5 R10: table walk
        for (int i = 0; i < NV; i++) begin
            ext_mode = VEC[i][13];
            wr(VEC[i][21:14]);
            chk("R1 R2 R3 R4 R10 outputs", {27'd0, strobe_n, autofd_n, init_n, selin_n, dir_in}, {27'd0, VEC[i][12:8]});
            chk("R5 readback", {24'd0, rdata}, {24'd0, VEC[i][7:0]});
        end

        // R10: mode changes act on held bit 5
        wr(8'h20);
        ext_mode = 1'b1; @(negedge clk);
        chk("R10 ext mode dir", {31'd0, dir_in}, 32'd1);
        ext_mode = 1'b0; @(negedge clk);
        chk("R10 printer mode dir", {31'd0, dir_in}, 32'd0);

        // R7: latency of exactly three edges
        wr(8'h10);
        ack_n = 1'b0; repeat (5) @(negedge clk);
        chk("R7 falling edge no irq", {31'd0, irq}, 32'd0);
        ack_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R7 irq not before third edge", {31'd0, irq}, 32'd0);
        @(negedge clk);
        chk("R7 irq after third edge", {31'd0, irq}, 32'd1);

        // R9: held until read
        repeat (5) @(negedge clk);
        chk("R9 irq held", {31'd0, irq}, 32'd1);
        rd();
        chk("R9 cleared by read", {31'd0, irq}, 32'd0);

        // R11: held high gives no further request
        repeat (6) @(negedge clk);
        chk("R11 single request per edge", {31'd0, irq}, 32'd0);

        // R9: clearing enable drops a pending request
        ack_n = 1'b0; repeat (4) @(negedge clk);
        ack_n = 1'b1; repeat (4) @(negedge clk);
        chk("R9 second request", {31'd0, irq}, 32'd1);
        wr(8'h00);
        chk("R9 cleared by disable", {31'd0, irq}, 32'd0);

        // R8: edges while disabled are not remembered
        ack_n = 1'b0; repeat (4) @(negedge clk);
        ack_n = 1'b1; repeat (4) @(negedge clk);
        chk("R8 disabled no irq", {31'd0, irq}, 32'd0);
        wr(8'h10);
        repeat (4) @(negedge clk);
        chk("R8 no stale request", {31'd0, irq}, 32'd0);

        finish_run();
    end
endmodule